// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block performs flush and invalidate maintenance on the state bits of a direct-mapped cache with 64-byte lines. A single command port takes the operation (flush or invalidate) and its scope. The scope is either the whole cache, one line named by its address, or a run of lines given by a start address and a byte length. Once a command is accepted, the block visits each affected line through a tag/state array port. It reads the stored tag, valid bit and dirty bit. It then writes back new state bits where the operation calls for it.

During a flush, each matching line that is both valid and dirty goes to the write-back buffer over a valid/ready handshake. After the buffer takes the line, the block clears the dirty bit and keeps the valid bit. Invalidate clears both bits of each targeted line and never uses the write-back buffer. When a command finishes, the block raises a one-cycle completion strobe with an error flag. The error flag reports rejected parameters.

Address layout used throughout: bits [5:0] are the byte offset within a line, bits [9:6] select one of 16 line slots, and the remaining upper bits are the tag. The line address handed to the write-back buffer is {tag, slot, 6'b0}.

Top module: `cache_maint_seq`

## Requirements
- R1: The line address on `wbAddr` is formed from the stored tag of the visited slot, the slot number in bits [9:6], and zeros in bits [5:0].
- R2: A flush of a line that is visited, matching and both valid and dirty presents the line on the write-back port. Once accepted, the line's dirty bit is cleared and its valid bit is kept.
- R3: A flush leaves a visited line untouched when that line is invalid, clean or holds a different tag. No write-back and no state write happen for such a line.
- R4: An invalidate clears both the valid and the dirty bit of every targeted line, whatever their prior values. It never raises `wbValid`.
- R5: Operation code 0 is flush and 1 is invalidate. Scope code 0 visits all 16 slots with no tag compare. Scope 1 visits the single line at `cmdAddr`. Scope 2 visits `cmdLen/64` consecutive lines from `cmdAddr`. Scopes 1 and 2 act only where the stored tag matches and the line is valid.
- R6: A command is rejected with `doneError`=1 on the cycle after acceptance, and no line state changes, in any of these cases: scope code 3; a line or range scope whose address has a nonzero offset; a range scope whose length is not a multiple of 64.
- R7: A range command with length zero completes with `doneStrobe`=1 and `doneError`=0 on the cycle after acceptance, and touches no line.
- R8: While `wbValid` is high and `wbReady` is low, the block holds `wbValid` and `wbAddr` and writes no state. It resumes once the line is accepted.
- R9: `cmdReady` is high only when no command is in progress. `doneStrobe` pulses for one cycle after the last line is processed, and a new command may be accepted in that same cycle.
- R10: After reset the block is idle: `cmdReady`=1, and `doneStrobe`, `wbValid` and `arrWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Block is idle and will take a command |
| cmdOp | input | 1 | 0 flush, 1 invalidate |
| cmdScope | input | 2 | 0 all, 1 line, 2 range, 3 reserved |
| cmdAddr | input | ADDR_W | Line or range start address |
| cmdLen | input | LEN_W | Range length in bytes |
| doneStrobe | output | 1 | One-cycle completion pulse |
| doneError | output | 1 | Invalid parameter flag, qualified by doneStrobe |
| arrIdx | output | IDX_W | Slot being visited |
| arrTag | input | TAG_W | Stored tag of the slot |
| arrValid | input | 1 | Stored valid bit |
| arrDirty | input | 1 | Stored dirty bit |
| arrWrEn | output | 1 | Write new state bits to the slot |
| arrWrValid | output | 1 | Valid bit to write |
| arrWrDirty | output | 1 | Dirty bit to write |
| wbValid | output | 1 | Line offered to the write-back buffer |
| wbReady | input | 1 | Write-back buffer accepts the line |
| wbAddr | output | ADDR_W | Line address offered for write-back |

## Verification
Two kinds of events can share a clock edge. The first pair is the completion strobe of one command and the acceptance of the next. The bench provokes this by issuing a flush of the whole cache and then presenting an invalidate in the very cycle its completion pulse is seen. It then checks that both completions arrive in order with the right status, and that the final array matches the effect of both commands. The second pair is a stall from the write-back buffer and the state write for the same line. The bench throttles `wbReady` during flushes, compares every accepted line address in order against a scoreboard, and confirms that the dirty bit changes only once the line is taken.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    SCOPE_ALL   = 2'd0,
    SCOPE_LINE  = 2'd1,
    SCOPE_RANGE = 2'd2,
    SCOPE_RSVD  = 2'd3
  } scope_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // latch an accepted command
    logic step;  // current line finished, move on
  } seqStrobe_t;
endpackage

// File: rtl/cms_datapath.sv
module cms_datapath
  import cms_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic                         cmdOp,
  input  logic [1:0]                   cmdScope,
  input  logic [ADDR_W-1:0]            cmdAddr,
  input  logic [LEN_W-1:0]             cmdLen,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0] arrTag,
  input  logic                         arrValid,
  output logic                         badParam,
  output logic                         zeroLen,
  output logic                         opInv,
  output logic                         lastLine,
  output logic                         lineHit,
  output logic [IDX_W-1:0]             arrIdx,
  output logic [ADDR_W-1:0]            wbAddr
);
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
  localparam int LN_W      = ADDR_W - OFF_W;
  localparam int NUM_LINES = 1 << IDX_W;
  localparam int CNT_A     = LEN_W - OFF_W + 1;
  localparam int CNT_W     = (CNT_A > IDX_W + 1) ? CNT_A : IDX_W + 1;

  logic [LN_W-1:0]  lineNo;
  logic [CNT_W-1:0] remain;
  logic             scopeAllQ;

  // parameter screening on the live command inputs
  always_comb begin
    badParam = (cmdScope == SCOPE_RSVD)
             | ((cmdScope != SCOPE_ALL) & (cmdAddr[OFF_W-1:0] != '0))
             | ((cmdScope == SCOPE_RANGE) & (cmdLen[OFF_W-1:0] != '0));
    zeroLen  = (cmdScope == SCOPE_RANGE) & (cmdLen == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineNo    <= '0;
      remain    <= '0;
      scopeAllQ <= 1'b0;
      opInv     <= 1'b0;
    end else if (strobe.load) begin
      opInv     <= cmdOp;
      scopeAllQ <= (cmdScope == SCOPE_ALL);
      unique case (cmdScope)
        SCOPE_ALL: begin
          lineNo <= '0;
          remain <= CNT_W'(NUM_LINES);
        end
        SCOPE_LINE: begin
          lineNo <= cmdAddr[ADDR_W-1:OFF_W];
          remain <= CNT_W'(1);
        end
        default: begin
          lineNo <= cmdAddr[ADDR_W-1:OFF_W];
          remain <= CNT_W'(cmdLen[LEN_W-1:OFF_W]);
        end
      endcase
    end else if (strobe.step) begin
      lineNo <= lineNo + LN_W'(1);
      remain <= remain - CNT_W'(1);
    end
  end

  always_comb begin
    arrIdx   = lineNo[IDX_W-1:0];
    lastLine = (remain == CNT_W'(1));
    lineHit  = scopeAllQ | (arrValid & (arrTag == lineNo[LN_W-1:IDX_W]));
    wbAddr   = {arrTag, arrIdx, {OFF_W{1'b0}}};
  end
endmodule

// File: rtl/cms_control.sv
module cms_control
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       badParam,
  input  logic       zeroLen,
  input  logic       opInv,
  input  logic       lastLine,
  input  logic       lineHit,
  input  logic       arrValid,
  input  logic       arrDirty,
  input  logic       wbReady,
  output logic       cmdReady,
  output seqStrobe_t strobe,
  output logic       doneStrobe,
  output logic       doneError,
  output logic       arrWrEn,
  output logic       arrWrValid,
  output logic       arrWrDirty,
  output logic       wbValid
);
  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e state;

  logic walking, accept, needWb, advance;

  always_comb begin
    walking     = (state == ST_WALK);
    cmdReady    = !walking;
    accept      = cmdReady & cmdValid;
    needWb      = walking & !opInv & lineHit & arrValid & arrDirty;
    wbValid     = needWb;
    advance     = walking & (!needWb | wbReady);
    arrWrEn     = walking & (opInv ? lineHit : (needWb & wbReady));
    arrWrValid  = !opInv;
    arrWrDirty  = 1'b0;
    strobe.load = accept & !badParam & !zeroLen;
    strobe.step = advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      doneStrobe <= 1'b0;
      doneError  <= 1'b0;
    end else begin
      doneStrobe <= 1'b0;
      doneError  <= 1'b0;
      if (accept) begin
        if (badParam) begin
          doneStrobe <= 1'b1;
          doneError  <= 1'b1;
        end else if (zeroLen) begin
          doneStrobe <= 1'b1;
        end else begin
          state <= ST_WALK;
        end
      end
      if (advance && lastLine) begin
        state      <= ST_IDLE;
        doneStrobe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cms_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdOp,
  input  logic [1:0]        cmdScope,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  output logic              doneStrobe,
  output logic              doneError,
  output logic [IDX_W-1:0]  arrIdx,
  input  logic [TAG_W-1:0]  arrTag,
  input  logic              arrValid,
  input  logic              arrDirty,
  output logic              arrWrEn,
  output logic              arrWrValid,
  output logic              arrWrDirty,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr
);
  seqStrobe_t strobe;
  logic badParam, zeroLen, opInv, lastLine, lineHit;

  cms_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdOp(cmdOp), .cmdScope(cmdScope), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .arrTag(arrTag), .arrValid(arrValid),
    .badParam(badParam), .zeroLen(zeroLen), .opInv(opInv),
    .lastLine(lastLine), .lineHit(lineHit), .arrIdx(arrIdx), .wbAddr(wbAddr)
  );

  cms_control ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .badParam(badParam), .zeroLen(zeroLen), .opInv(opInv),
    .lastLine(lastLine), .lineHit(lineHit),
    .arrValid(arrValid), .arrDirty(arrDirty), .wbReady(wbReady),
    .cmdReady(cmdReady), .strobe(strobe),
    .doneStrobe(doneStrobe), .doneError(doneError),
    .arrWrEn(arrWrEn), .arrWrValid(arrWrValid), .arrWrDirty(arrWrDirty),
    .wbValid(wbValid)
  );
endmodule

// File: rtl/cache_maint_seq_checker.sv
module cache_maint_seq_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdScope,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [LEN_W-1:0]  cmdLen,
  input logic              doneStrobe,
  input logic              doneError,
  input logic              arrWrEn,
  input logic              arrWrValid,
  input logic              arrWrDirty,
  input logic              wbValid,
  input logic              wbReady,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              opInv
);
  logic takeBad, takeZero;
  always_comb begin
    takeBad  = cmdValid && cmdReady &&
               ((cmdScope == 2'd3) ||
                ((cmdScope != 2'd0) && (cmdAddr[OFF_W-1:0] != '0)) ||
                ((cmdScope == 2'd2) && (cmdLen[OFF_W-1:0] != '0)));
    takeZero = cmdValid && cmdReady && (cmdScope == 2'd2) && (cmdLen == '0);
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !wbReady |=> wbValid && $stable(wbAddr));

  assert_stall_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !wbReady |-> !arrWrEn);

  assert_flush_keeps_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn && !opInv |-> arrWrValid && !arrWrDirty && wbValid && wbReady);

  assert_inval_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn && opInv |-> !arrWrValid && !arrWrDirty && !wbValid);

  assert_bad_param_R6: assert property (@(posedge clk) disable iff (!rstN)
    takeBad |=> doneStrobe && doneError && !arrWrEn);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    takeZero |=> doneStrobe && !doneError && !arrWrEn);

  assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> cmdReady);

  assert_no_wb_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !wbValid && !arrWrEn);
endmodule

bind cache_maint_seq cache_maint_seq_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)
) chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdScope(cmdScope), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
  .doneStrobe(doneStrobe), .doneError(doneError),
  .arrWrEn(arrWrEn), .arrWrValid(arrWrValid), .arrWrDirty(arrWrDirty),
  .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .opInv(opInv)
);

// File: tb/cache_maint_seq_test.sv
module cache_maint_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 6;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int NUM_LINES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady, cmdOp = 1'b0;
  logic [1:0] cmdScope = 2'd0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [LEN_W-1:0] cmdLen = '0;
  logic doneStrobe, doneError;
  logic [IDX_W-1:0] arrIdx;
  logic [TAG_W-1:0] arrTag;
  logic arrValid, arrDirty, arrWrEn, arrWrValid, arrWrDirty;
  logic wbValid, wbReady = 1'b1;
  logic [ADDR_W-1:0] wbAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_maint_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdScope(cmdScope), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .doneStrobe(doneStrobe), .doneError(doneError),
    .arrIdx(arrIdx), .arrTag(arrTag), .arrValid(arrValid), .arrDirty(arrDirty),
    .arrWrEn(arrWrEn), .arrWrValid(arrWrValid), .arrWrDirty(arrWrDirty),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr)
  );

  // tag/state array model
  logic [TAG_W-1:0] memTag [NUM_LINES];
  logic memV [NUM_LINES];
  logic memD [NUM_LINES];
  logic expV [NUM_LINES];
  logic expD [NUM_LINES];
  assign arrTag   = memTag[arrIdx];
  assign arrValid = memV[arrIdx];
  assign arrDirty = memD[arrIdx];
  always @(posedge clk) if (arrWrEn) begin
    memV[arrIdx] <= arrWrValid;
    memD[arrIdx] <= arrWrDirty;
  end

  // write-back buffer throttling
  logic stallOn = 1'b0;
  logic [1:0] stallCnt = '0;
  always @(negedge clk) begin
    stallCnt <= stallCnt + 2'd1;
    wbReady  <= stallOn ? (stallCnt == 2'd3) : 1'b1;
  end

  int checks = 0, fails = 0, issued = 0, doneSeen = 0, stallSeen = 0;
  bit finished = 1'b0;
  logic [ADDR_W-1:0] wbExp[$];
  string wbReq[$];
  logic stExp[$];
  string stReq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx), {OFF_W{1'b0}}};
  endfunction

  // monitor: pops the scoreboard as results appear
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      if (wbValid && !wbReady) stallSeen++;
      if (wbValid && wbReady) begin
        if (wbExp.size() == 0) check(1'b0, "R3", "unexpected write-back", wbAddr, 0);
        else begin
          automatic logic [ADDR_W-1:0] e = wbExp.pop_front();
          automatic string r = wbReq.pop_front();
          check(wbAddr == e, r, "write-back address", wbAddr, e);
        end
      end
      if (doneStrobe) begin
        doneSeen++;
        if (stExp.size() == 0) check(1'b0, "R9", "unexpected done", 1, 0);
        else begin
          automatic logic e = stExp.pop_front();
          automatic string r = stReq.pop_front();
          check(doneError == e, r, "done status", doneError, e);
        end
      end
    end
  end

  // driver: predicts effect, pushes expectations, then drives the command
  task automatic issue(input logic op, input logic [1:0] scope,
                       input logic [ADDR_W-1:0] addr, input logic [LEN_W-1:0] len,
                       input string req, input bit atDone);
    automatic bit bad = (scope == 2'd3) ||
                        (scope != 2'd0 && addr[OFF_W-1:0] != 0) ||
                        (scope == 2'd2 && len[OFF_W-1:0] != 0);
    automatic bit zero = !bad && scope == 2'd2 && len == 0;
    automatic int n = 0;
    automatic logic [ADDR_W-OFF_W-1:0] ln = addr[ADDR_W-1:OFF_W];
    if (!bad) begin
      n = (scope == 2'd0) ? NUM_LINES : (scope == 2'd1) ? 1 : int'(len) / 64;
      if (scope == 2'd0) ln = '0;
      for (int k = 0; k < n; k++) begin
        automatic int idx = int'(ln[IDX_W-1:0]);
        automatic bit hit = (scope == 2'd0) ||
                            (expV[idx] && memTag[idx] == ln[ADDR_W-OFF_W-1:IDX_W]);
        if (op == 1'b0) begin
          if (hit && expV[idx] && expD[idx]) begin
            wbExp.push_back(mkAddr(int'(memTag[idx]), idx));
            wbReq.push_back({req, " R1"});
            expD[idx] = 1'b0;
          end
        end else if (hit) begin
          expV[idx] = 1'b0;
          expD[idx] = 1'b0;
        end
        ln = ln + 1'b1;
      end
    end
    stExp.push_back(bad);
    stReq.push_back(req);
    issued++;
    if (atDone) begin
      do @(negedge clk); while (!doneStrobe);
      check(cmdReady == 1'b1, "R9", "ready in done cycle", cmdReady, 1);
    end else begin
      do @(negedge clk); while (!cmdReady);
    end
    cmdOp = op; cmdScope = scope; cmdAddr = addr; cmdLen = len; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    if (bad || zero)
      check(doneStrobe == 1'b1, req, "done one cycle after accept", doneStrobe, 1);
  endtask

  task automatic waitIdle(input string req);
    automatic int mism = 0;
    while (doneSeen < issued) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_LINES; i++)
      if (memV[i] != expV[i] || memD[i] != expD[i]) mism++;
    check(mism == 0, req, "array state mismatching lines", mism, 0);
    check(wbExp.size() == 0, req, "missing write-backs", wbExp.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < NUM_LINES; i++) begin
      memTag[i] = TAG_W'((i % 3) + 1);
      memV[i]   = (i != 5);
      memD[i]   = (i % 2 == 0) || (i == 5);
      expV[i]   = memV[i];
      expD[i]   = memD[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1, "R10", "ready after reset", cmdReady, 1);
    check(doneStrobe == 1'b0, "R10", "done after reset", doneStrobe, 0);
    check(wbValid == 1'b0 && arrWrEn == 1'b0, "R10", "wb/write after reset",
          {wbValid, arrWrEn}, 0);

    issue(1'b0, 2'd1, mkAddr(int'(memTag[2]), 2), '0, "R2", 1'b0);
    waitIdle("R2");
    issue(1'b0, 2'd1, mkAddr(int'(memTag[3]), 3), '0, "R3", 1'b0);
    waitIdle("R3");
    issue(1'b0, 2'd1, mkAddr(int'(memTag[5]), 5), '0, "R3", 1'b0);
    waitIdle("R3");
    issue(1'b0, 2'd1, mkAddr(int'(memTag[4]), 4) + 4, '0, "R6", 1'b0);
    waitIdle("R6");
    issue(1'b0, 2'd2, mkAddr(1, 0), 16'd100, "R6", 1'b0);
    waitIdle("R6");
    issue(1'b1, 2'd3, mkAddr(1, 0), 16'd64, "R6", 1'b0);
    waitIdle("R6");
    issue(1'b1, 2'd1, mkAddr(int'(memTag[6]), 6) + 32, '0, "R6", 1'b0);
    waitIdle("R6");
    issue(1'b0, 2'd2, mkAddr(1, 0), 16'd0, "R7", 1'b0);
    waitIdle("R7");

    stallOn = 1'b1;
    issue(1'b0, 2'd2, mkAddr(1, 0), 16'(16 * 64), "R5 R2", 1'b0);
    waitIdle("R5");
    check(stallSeen > 0, "R8", "stall cycles observed", stallSeen, 1);

    // restore some dirt, then flush all and invalidate in the done cycle
    for (int i = 0; i < NUM_LINES; i += 4) begin
      memD[i] = 1'b1;
      expD[i] = 1'b1;
    end
    issue(1'b0, 2'd0, '0, '0, "R9 R5", 1'b0);
    issue(1'b1, 2'd1, mkAddr(int'(memTag[7]), 7), '0, "R9 R4", 1'b1);
    waitIdle("R9");
    stallOn = 1'b0;

    issue(1'b1, 2'd1, mkAddr(7, 8), '0, "R4 R3", 1'b0);
    waitIdle("R4");
    issue(1'b1, 2'd2, mkAddr(2, 1), 16'(4 * 64), "R4 R5", 1'b0);
    waitIdle("R4");
    for (int i = 0; i < NUM_LINES; i += 3) begin
      memD[i] = 1'b1;
      expD[i] = 1'b1;
    end
    issue(1'b1, 2'd0, '0, '0, "R4", 1'b0);
    waitIdle("R4");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule